// File: doc/BRIEF.md
# Byte-Lane Flow-Through Synchronous SRAM

This block is a single-port synchronous memory. Each word holds 32 data bits in four byte lanes, and each lane carries one parity bit. A burst sequencer outside this block supplies the word address and a chip-select flag each cycle. At every rising clock edge the block samples the address, the write controls and the write data. In the cycle that follows, it either writes the chosen lanes or presents the addressed word on its read outputs.

Reads use flow-through timing. The address register drives the storage array directly, so the word appears at the outputs in the same cycle that follows its address edge. No output register sits on the read path.

A global write strobe stores the whole word. A byte-write strobe stores only the lanes picked by four active-low lane selects. An asynchronous active-low output enable gates the read outputs. The outputs also shut off by themselves during write cycles and while the chip is deselected. When the outputs are off, the data and parity outputs read as zero.

Top module: `lane_sram`

## Requirements
- R1: While reset is held, and in the first cycle after it, `dout_en_o` is 0 and `rdata_o`/`rpar_o` are all zero.
- R2: With `sel_i`=1 and `gw_n`=0 sampled at an edge, all four data bytes and all four parity bits at `addr_i` take `wdata_i`/`wpar_i`, whatever `bwe_n` and `bsel_n` are.
- R3: With `sel_i`=1, `gw_n`=1 and `bwe_n`=0 sampled, only the lanes whose `bsel_n` bit is 0 are written; the other lanes keep their old contents.
- R4: Lane i (i = 0..3) is `bsel_n[i]`; it covers `wdata_i[8i+7:8i]` and `wpar_i[i]` and is read back on `rdata_o[8i+7:8i]` and `rpar_o[i]`.
- R5: A read cycle (`sel_i`=1, no write condition) shows the word at the address sampled at the previous rising edge, in the cycle straight after that edge, with no extra delay.
- R6: `oe_n`=1 turns the outputs off at once, with no clock edge needed: `dout_en_o`=0 and data/parity are zero. Lowering `oe_n` again brings the read word back within the same cycle.
- R7: In the cycle after a write is sampled, `dout_en_o`=0 and the outputs are zero, even with `oe_n`=0.
- R8: With `sel_i`=0 sampled, nothing is written, whatever the write controls are, and the outputs are off in the following cycle.
- R9: `bwe_n`=0 with `bsel_n`=4'b1111 and `gw_n`=1 writes nothing and is a read cycle.
- R10: With `gw_n`=1 and `bwe_n`=1, `bsel_n` has no effect: the cycle is a read and the memory is unchanged.
- R11: A read of an address in the cycle straight after a write to that address returns the newly written lanes.
- R12: Every word reads as zero before its first write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset of the cycle-control registers |
| sel_i | input | 1 | Chip selected, from the burst sequencer |
| addr_i | input | AW | Word address from the burst sequencer |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| bsel_n | input | LANES | Per-lane byte selects, active low |
| wdata_i | input | LANES*LANE_W | Write data |
| wpar_i | input | LANES | Write parity, one bit per lane |
| oe_n | input | 1 | Asynchronous output enable, active low |
| rdata_o | output | LANES*LANE_W | Read data, zero when outputs are off |
| rpar_o | output | LANES | Read parity, zero when outputs are off |
| dout_en_o | output | 1 | Outputs driving |

## Verification
Two functions can meet in one cycle: the commit of a write sampled at an edge, and a flow-through read of the same address sampled at that same edge. The bench provokes this by following every byte-mask write at once with a read of its address. It judges the result against a lane-merged reference word. A second overlap occurs between the asynchronous output enable and a read cycle that is in progress. The bench toggles `oe_n` between clock edges and expects the outputs to go dark and then come back with no edge in between.

// File: rtl/lane_sram_pkg.sv
package lane_sram_pkg;
   typedef enum logic [1:0] {
      CYC_IDLE  = 2'd0,
      CYC_READ  = 2'd1,
      CYC_WRITE = 2'd2
   } cyc_kind_e;
endpackage

// File: rtl/lane_sram_wdec.sv
module lane_sram_wdec
   import lane_sram_pkg::*;
#(
   parameter int LANES = 4
) (
   input  logic             sel,
   input  logic             gw_n,
   input  logic             bwe_n,
   input  logic [LANES-1:0] bsel_n,
   output cyc_kind_e        kind,
   output logic [LANES-1:0] lane_we
);
   logic byte_hit;

   // a byte write only counts when at least one lane is picked
   assign byte_hit = !bwe_n && (bsel_n != {LANES{1'b1}});

   always_comb begin
      lane_we = '0;
      if (!sel) begin
         kind = CYC_IDLE;
      end else if (!gw_n) begin
         kind    = CYC_WRITE;
         lane_we = {LANES{1'b1}};
      end else if (byte_hit) begin
         kind    = CYC_WRITE;
         lane_we = ~bsel_n;
      end else begin
         kind = CYC_READ;
      end
   end
endmodule

// File: rtl/lane_sram_array.sv
module lane_sram_array #(
   parameter int DEPTH  = 64,
   parameter int LANES  = 4,
   parameter int LANE_W = 8,
   localparam int AW    = $clog2(DEPTH),
   localparam int DW    = LANES * LANE_W
) (
   input  logic             clk,
   input  logic [AW-1:0]    addr,
   input  logic [LANES-1:0] lane_we,
   input  logic [DW-1:0]    wdata,
   input  logic [LANES-1:0] wpar,
   output logic [DW-1:0]    rdata,
   output logic [LANES-1:0] rpar
);
   for (genvar g = 0; g < LANES; g++) begin : g_lane
      // each lane stores its parity bit on top of its data byte
      logic [LANE_W:0] mem [DEPTH];

      initial begin
         for (int i = 0; i < DEPTH; i++) mem[i] = '0;
      end

      always_ff @(posedge clk) begin
         if (lane_we[g]) mem[addr] <= {wpar[g], wdata[g*LANE_W +: LANE_W]};
      end

      assign rdata[g*LANE_W +: LANE_W] = mem[addr][LANE_W-1:0];
      assign rpar[g]                   = mem[addr][LANE_W];
   end
endmodule

// File: rtl/lane_sram_oe.sv
module lane_sram_oe
   import lane_sram_pkg::*;
#(
   parameter int LANES  = 4,
   parameter int LANE_W = 8,
   localparam int DW    = LANES * LANE_W
) (
   input  logic             oe_n,
   input  cyc_kind_e        kind,
   input  logic [DW-1:0]    arr_data,
   input  logic [LANES-1:0] arr_par,
   output logic [DW-1:0]    rdata,
   output logic [LANES-1:0] rpar,
   output logic             dout_en
);
   assign dout_en = !oe_n && (kind == CYC_READ);
   assign rdata   = dout_en ? arr_data : '0;
   assign rpar    = dout_en ? arr_par  : '0;
endmodule

// File: rtl/lane_sram.sv
module lane_sram
   import lane_sram_pkg::*;
#(
   parameter int DEPTH  = 64,
   parameter int LANES  = 4,
   parameter int LANE_W = 8,
   localparam int AW    = $clog2(DEPTH),
   localparam int DW    = LANES * LANE_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sel_i,
   input  logic [AW-1:0]    addr_i,
   input  logic             gw_n,
   input  logic             bwe_n,
   input  logic [LANES-1:0] bsel_n,
   input  logic [DW-1:0]    wdata_i,
   input  logic [LANES-1:0] wpar_i,
   input  logic             oe_n,
   output logic [DW-1:0]    rdata_o,
   output logic [LANES-1:0] rpar_o,
   output logic             dout_en_o
);
   if (DEPTH < 2 || (1 << AW) != DEPTH) begin : g_bad_depth
      $error("lane_sram: DEPTH must be a power of two, at least 2");
   end
   if (LANES < 1 || LANE_W < 1) begin : g_bad_lane
      $error("lane_sram: LANES and LANE_W must be positive");
   end

   cyc_kind_e        kind_d, kind_q;
   logic [LANES-1:0] lane_we_d, lane_we_q;
   logic [AW-1:0]    addr_q;
   logic [DW-1:0]    wdata_q, arr_data;
   logic [LANES-1:0] wpar_q, arr_par;

   lane_sram_wdec #(.LANES(LANES)) u_wdec (
      .sel     (sel_i),
      .gw_n    (gw_n),
      .bwe_n   (bwe_n),
      .bsel_n  (bsel_n),
      .kind    (kind_d),
      .lane_we (lane_we_d)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         kind_q    <= CYC_IDLE;
         lane_we_q <= '0;
      end else begin
         kind_q    <= kind_d;
         lane_we_q <= lane_we_d;
      end
   end

   always_ff @(posedge clk) begin
      addr_q  <= addr_i;
      wdata_q <= wdata_i;
      wpar_q  <= wpar_i;
   end

   lane_sram_array #(.DEPTH(DEPTH), .LANES(LANES), .LANE_W(LANE_W)) u_array (
      .clk     (clk),
      .addr    (addr_q),
      .lane_we (lane_we_q),
      .wdata   (wdata_q),
      .wpar    (wpar_q),
      .rdata   (arr_data),
      .rpar    (arr_par)
   );

   lane_sram_oe #(.LANES(LANES), .LANE_W(LANE_W)) u_oe (
      .oe_n     (oe_n),
      .kind     (kind_q),
      .arr_data (arr_data),
      .arr_par  (arr_par),
      .rdata    (rdata_o),
      .rpar     (rpar_o),
      .dout_en  (dout_en_o)
   );

   AST_GW_ALL_LANES: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_i && !gw_n) |=> (lane_we_q == {LANES{1'b1}})); // R2
   AST_BYTE_LANES: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_i && gw_n && !bwe_n) |=> (lane_we_q == ~$past(bsel_n))); // R3
   AST_WRITE_OUT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_i && !gw_n) |=> !dout_en_o); // R7
   AST_DESEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !sel_i |=> (lane_we_q == '0 && !dout_en_o && rdata_o == '0)); // R8
   AST_OE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      oe_n |-> (!dout_en_o && rpar_o == '0)); // R6
   AST_NO_BSEL_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
      (gw_n && bwe_n) |=> (lane_we_q == '0)); // R10
endmodule

// File: tb/lane_sram_test.sv
`timescale 1ns/1ps
module lane_sram_test;
   localparam int DEPTH = 16;
   localparam int AW    = 4;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        sel_i, gw_n, bwe_n, oe_n;
   logic [AW-1:0] addr_i;
   logic [3:0]  bsel_n, wpar_i, rpar_o;
   logic [31:0] wdata_i, rdata_o;
   logic        dout_en_o;

   int checks   = 0;
   int failures = 0;
   bit done     = 0;

   // model word layout: {parity[3:0], data[31:0]}
   logic [35:0] model [DEPTH];
   logic        pend_wr;
   logic [3:0]  pend_mask;
   logic [AW-1:0] pend_addr;
   logic [31:0] pend_d;
   logic [3:0]  pend_p;

   always #2.5 clk = ~clk;

   lane_sram #(.DEPTH(DEPTH)) uut (
      .clk(clk), .rst_n(rst_n), .sel_i(sel_i), .addr_i(addr_i),
      .gw_n(gw_n), .bwe_n(bwe_n), .bsel_n(bsel_n), .wdata_i(wdata_i),
      .wpar_i(wpar_i), .oe_n(oe_n), .rdata_o(rdata_o), .rpar_o(rpar_o),
      .dout_en_o(dout_en_o)
   );

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic check_outputs(input string req, input logic en, input logic [35:0] w);
      check({req, " en"}, 64'(dout_en_o), 64'(en));
      check({req, " data"}, 64'({rpar_o, rdata_o}), en ? 64'(w) : 64'd0);
   endtask

   // one bus cycle; outputs checked 1 ns after the capturing edge
   task automatic step(input string req, input logic s, input logic [AW-1:0] a,
                       input logic g, input logic b, input logic [3:0] bs,
                       input logic [31:0] d, input logic [3:0] p);
      logic wr;
      logic [3:0] mask;
      @(negedge clk);
      sel_i = s; addr_i = a; gw_n = g; bwe_n = b; bsel_n = bs; wdata_i = d; wpar_i = p;
      @(posedge clk);
      #1;
      if (pend_wr) begin
         for (int i = 0; i < 4; i++) begin
            if (pend_mask[i]) begin
               model[pend_addr][8*i +: 8] = pend_d[8*i +: 8];
               model[pend_addr][32+i]     = pend_p[i];
            end
         end
      end
      wr   = s && (!g || (!b && bs != 4'hF));
      mask = !g ? 4'hF : ~bs;
      check_outputs(req, !oe_n && s && !wr, model[a]);
      pend_wr = wr; pend_mask = mask; pend_addr = a; pend_d = d; pend_p = p;
   endtask

   task automatic rd(input string req, input logic [AW-1:0] a);
      step(req, 1'b1, a, 1'b1, 1'b1, 4'hF, 32'h0, 4'h0);
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < DEPTH; i++) model[i] = '0;
      pend_wr = 0; pend_mask = 0; pend_addr = 0; pend_d = 0; pend_p = 0;
      rst_n = 0; sel_i = 1; addr_i = 0; gw_n = 0; bwe_n = 0; bsel_n = 0;
      wdata_i = 32'hFFFF_FFFF; wpar_i = 4'hF; oe_n = 0;
      // R1: outputs quiet under reset even with a write pending on the pins
      repeat (3) @(posedge clk);
      #1 check_outputs("R1 in reset", 1'b0, 36'h0);
      @(negedge clk);
      sel_i = 0; gw_n = 1; bwe_n = 1; bsel_n = 4'hF;
      rst_n = 1;
      @(posedge clk); #1 check_outputs("R1 after reset", 1'b0, 36'h0);

      // R12 R5: zero contents, flow-through read per address
      for (int a = 0; a < DEPTH; a++) rd("R12 R5 initial read", AW'(a));

      // R2 R7: global write overrides byte controls, outputs off during write
      for (int a = 0; a < DEPTH; a++)
         step("R2 R7 global write", 1'b1, AW'(a), 1'b0, a[0], 4'(a),
              32'hA500_0000 ^ (32'(a) * 32'h0103_0507), 4'(~a));
      for (int a = 0; a < DEPTH; a++) rd("R2 R4 readback", AW'(a));

      // R3 R4 R9 R11: every lane mask, read immediately after the write
      for (int m = 0; m < 16; m++) begin
         step("R3 R9 byte write", 1'b1, AW'(m), 1'b1, 1'b0, 4'(m),
              32'h1122_3344 + 32'(m) * 32'h1010_1010, 4'(m ^ 5));
         rd("R3 R4 R11 same-address read", AW'(m));
      end

      // R10: selects ignored without a write enable
      for (int m = 0; m < 16; m++) begin
         step("R10 no enable", 1'b1, AW'(m), 1'b1, 1'b1, 4'(m), 32'hDEAD_BEEF, 4'hA);
         rd("R10 unchanged", AW'(m));
      end

      // R8: deselected cycles never write
      for (int a = 0; a < 4; a++) begin
         step("R8 deselected", 1'b0, AW'(a), 1'b0, 1'b0, 4'h0, 32'h0BAD_0BAD, 4'h6);
         rd("R8 unchanged", AW'(a));
      end

      // R6: asynchronous output enable inside a read cycle
      for (int a = 4; a < 8; a++) begin
         rd("R6 read", AW'(a));
         #0.4 oe_n = 1;
         #0.3 check_outputs("R6 oe high", 1'b0, model[a]);
         oe_n = 0;
         #0.3 check_outputs("R6 oe low again", 1'b1, model[a]);
      end
      oe_n = 1;
      rd("R6 oe held high", 4'd9);
      oe_n = 0;
      // R7: write with oe low still keeps the outputs dark
      step("R7 write oe low", 1'b1, 4'd9, 1'b1, 1'b0, 4'b0110, 32'h5A5A_5A5A, 4'h9);
      rd("R11 after write", 4'd9);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule